// File: doc/BRIEF.md
# Reset-Addressed Serial Delay Memory

This block is a dual-port serial memory that acts as a programmable digital delay line. It stores words of `WORD_W` bits (4 by default) in a ring of `DEPTH` locations. The write side and the read side each have their own clock, enable and synchronous active-high pointer reset. Each side walks its own address pointer through the ring, one location per enabled clock. There are no full or empty flags. The distance between the written stream and the read stream comes only from when each side's reset was last applied.

In use, the producer pulses the write reset at the start of a field and streams words in. The consumer pulses the read reset some number of its own clocks later and streams the same words out in order. Either side may pause its enable, or have its clock stopped high or low for any length of time. Stored words and the pointer positions survive such a pause. The read side returns location 0 on the same clock edge that carries its reset, so there are no extra latency cycles after a reset.

Top module: `fieldmem_delay`

## Requirements
- R1: On a rising `wr_clk` with `wr_en` high, `wr_data` is stored at the current write location. With `wr_en` low, nothing is stored.
- R2: `wr_rst` high at a rising `wr_clk` makes location 0 the write location for that edge and has priority over the held pointer. If `wr_en` is also high, the word goes to location 0 and the next write location is 1. If `wr_en` is low, the next write location is 0.
- R3: Without `wr_rst`, the write pointer advances by exactly one on each enabled edge and wraps from `DEPTH`-1 to 0. Without `wr_en`, it holds.
- R4: `rd_rst` high at a rising `rd_clk` makes location 0 the read location for that edge. When `rd_en` is also high, `rd_data` holds the word at location 0 right after that same edge, and the next read location is 1.
- R5: Without `rd_rst`, the read pointer advances by exactly one on each enabled edge and wraps from `DEPTH`-1 to 0. Without `rd_en`, it holds.
- R6: `rd_data` is a register. It changes only on a rising `rd_clk` with `rd_en` high and otherwise keeps its value.
- R7: After a write reset and a later read reset, the enabled reads return the enabled writes in the same order, across the wrap. This holds as long as the reader neither overtakes the writer nor falls a full `DEPTH` words behind. The two streams may run at the same time on unrelated clocks.
- R8: Stopping either clock for any length of time, high or low, loses neither stored words nor pointer positions.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wr_clk | input | 1 | Write-side clock |
| wr_rst | input | 1 | Synchronous write pointer reset, active high |
| wr_en | input | 1 | Write enable; stores a word and advances the write pointer |
| wr_data | input | WORD_W | Word to store |
| rd_clk | input | 1 | Read-side clock, unrelated to `wr_clk` |
| rd_rst | input | 1 | Synchronous read pointer reset, active high |
| rd_en | input | 1 | Read enable; loads `rd_data` and advances the read pointer |
| rd_data | output | WORD_W | Registered read word |

## Verification
The pointer properties assume each side has seen at least one reset of its own before they are checked. They stay disabled until that reset, so the unknown pointers at power-up are never judged. The design leaves the result undefined when a read and a write hit the same location close together in time on asynchronous clocks. The stimulus avoids this: in each phase the reader starts at least a dozen writes behind the writer, runs on a slower clock, and never trails by more than the ring depth. Each phase also starts with a write reset followed by a read reset, so the expected queue always begins at location 0.

// File: rtl/fmem_pkg.sv
package fmem_pkg;

  localparam int DEF_WORD_W = 4;
  localparam int DEF_DEPTH  = 1024;

  // Pointer width for a ring of the given depth (at least one bit).
  function automatic int fmem_addr_w(input int depth);
    return (depth > 1) ? $clog2(depth) : 1;
  endfunction

  // True when the ring depth fills the pointer range exactly.
  function automatic bit fmem_is_pow2(input int depth);
    return (depth > 0) && ((depth & (depth - 1)) == 0);
  endfunction

endpackage

// File: rtl/fmem_seq_ctr.sv
module fmem_seq_ctr
  import fmem_pkg::*;
#(
  parameter int DEPTH  = DEF_DEPTH,
  parameter int ADDR_W = fmem_addr_w(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  output logic [ADDR_W-1:0] acc_addr,
  output logic [ADDR_W-1:0] held_addr
);

  localparam logic [ADDR_W-1:0] LAST = ADDR_W'(DEPTH - 1);

  logic [ADDR_W-1:0] addr_q;
  logic [ADDR_W-1:0] step;

  // The location used on this edge: a reset overrides the held pointer.
  assign acc_addr  = rst ? '0 : addr_q;
  assign held_addr = addr_q;

  generate
    if (fmem_is_pow2(DEPTH)) begin : g_wrap_free
      assign step = acc_addr + 1'b1;
    end else begin : g_wrap_cmp
      assign step = (acc_addr == LAST) ? '0 : acc_addr + 1'b1;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (en) begin
      addr_q <= step;
    end else if (rst) begin
      addr_q <= '0;
    end
  end

endmodule

// File: rtl/fmem_store.sv
module fmem_store
  import fmem_pkg::*;
#(
  parameter int WORD_W = DEF_WORD_W,
  parameter int DEPTH  = DEF_DEPTH,
  parameter int ADDR_W = fmem_addr_w(DEPTH)
) (
  input  logic              wr_clk,
  input  logic              wr_we,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [WORD_W-1:0] wr_word,
  input  logic              rd_clk,
  input  logic              rd_re,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [WORD_W-1:0] rd_word
);

  logic [WORD_W-1:0] cells [DEPTH];

  // Simple dual-port, two-clock array with a registered read port.
  always_ff @(posedge wr_clk) begin
    if (wr_we) begin
      cells[wr_addr] <= wr_word;
    end
  end

  always_ff @(posedge rd_clk) begin
    if (rd_re) begin
      rd_word <= cells[rd_addr];
    end
  end

endmodule

// File: rtl/fieldmem_delay.sv
module fieldmem_delay
  import fmem_pkg::*;
#(
  parameter int WORD_W = DEF_WORD_W,
  parameter int DEPTH  = DEF_DEPTH
) (
  input  logic              wr_clk,
  input  logic              wr_rst,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              rd_clk,
  input  logic              rd_rst,
  input  logic              rd_en,
  output logic [WORD_W-1:0] rd_data
);

  localparam int ADDR_W = fmem_addr_w(DEPTH);

  logic [ADDR_W-1:0] wr_addr_now;
  logic [ADDR_W-1:0] wptr_q;
  logic [ADDR_W-1:0] rd_addr_now;
  logic [ADDR_W-1:0] rptr_q;

  fmem_seq_ctr #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_wr_ctr (
    .clk       (wr_clk),
    .rst       (wr_rst),
    .en        (wr_en),
    .acc_addr  (wr_addr_now),
    .held_addr (wptr_q)
  );

  fmem_seq_ctr #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_rd_ctr (
    .clk       (rd_clk),
    .rst       (rd_rst),
    .en        (rd_en),
    .acc_addr  (rd_addr_now),
    .held_addr (rptr_q)
  );

  fmem_store #(.WORD_W(WORD_W), .DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_store (
    .wr_clk  (wr_clk),
    .wr_we   (wr_en),
    .wr_addr (wr_addr_now),
    .wr_word (wr_data),
    .rd_clk  (rd_clk),
    .rd_re   (rd_en),
    .rd_addr (rd_addr_now),
    .rd_word (rd_data)
  );

endmodule

// File: rtl/fieldmem_delay_chk.sv
module fieldmem_delay_chk #(
  parameter int WORD_W = 4,
  parameter int DEPTH  = 1024,
  parameter int ADDR_W = 10
) (
  input logic              wr_clk,
  input logic              wr_rst,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_ptr,
  input logic              rd_clk,
  input logic              rd_rst,
  input logic              rd_en,
  input logic [ADDR_W-1:0] rd_ptr,
  input logic [WORD_W-1:0] rd_data
);

  localparam logic [ADDR_W-1:0] LAST = ADDR_W'(DEPTH - 1);

  logic w_armed = 1'b0;
  logic r_armed = 1'b0;

  always_ff @(posedge wr_clk) if (wr_rst) w_armed <= 1'b1;
  always_ff @(posedge rd_clk) if (rd_rst) r_armed <= 1'b1;

  // R2: write reset lands the pointer on 0 or 1 depending on enable
  a_r2_wr_rst_idle: assert property (@(posedge wr_clk) disable iff (!w_armed)
    (wr_rst && !wr_en) |=> (wr_ptr == '0));
  a_r2_wr_rst_write: assert property (@(posedge wr_clk) disable iff (!w_armed)
    (wr_rst && wr_en) |=> (wr_ptr == ADDR_W'(1)));

  // R3: single step with wrap, hold when idle, never out of range
  a_r3_wr_step: assert property (@(posedge wr_clk) disable iff (!w_armed)
    (!wr_rst && wr_en) |=>
      (wr_ptr == (($past(wr_ptr) == LAST) ? '0 : ADDR_W'($past(wr_ptr) + 1'b1))));
  a_r3_wr_hold: assert property (@(posedge wr_clk) disable iff (!w_armed)
    (!wr_rst && !wr_en) |=> $stable(wr_ptr));
  a_r3_wr_range: assert property (@(posedge wr_clk) disable iff (!w_armed)
    wr_ptr <= LAST);

  // R4: read reset with enable leaves the pointer on 1
  a_r4_rd_rst_read: assert property (@(posedge rd_clk) disable iff (!r_armed)
    (rd_rst && rd_en) |=> (rd_ptr == ADDR_W'(1)));

  // R5: read pointer steps and holds like the write pointer
  a_r5_rd_step: assert property (@(posedge rd_clk) disable iff (!r_armed)
    (!rd_rst && rd_en) |=>
      (rd_ptr == (($past(rd_ptr) == LAST) ? '0 : ADDR_W'($past(rd_ptr) + 1'b1))));
  a_r5_rd_hold: assert property (@(posedge rd_clk) disable iff (!r_armed)
    (!rd_rst && !rd_en) |=> $stable(rd_ptr));

  // R6: output register frozen while reads are disabled
  a_r6_rd_data_hold: assert property (@(posedge rd_clk) disable iff (!r_armed)
    !rd_en |=> $stable(rd_data));

endmodule

bind fieldmem_delay fieldmem_delay_chk #(
  .WORD_W (WORD_W),
  .DEPTH  (DEPTH),
  .ADDR_W (ADDR_W)
) chk_i (
  .wr_clk  (wr_clk),
  .wr_rst  (wr_rst),
  .wr_en   (wr_en),
  .wr_ptr  (wptr_q),
  .rd_clk  (rd_clk),
  .rd_rst  (rd_rst),
  .rd_en   (rd_en),
  .rd_ptr  (rptr_q),
  .rd_data (rd_data)
);

// File: tb/fieldmem_delay_tb_top.sv
module fieldmem_delay_tb_top;

  localparam int W     = 4;
  localparam int DEPTH = 64;

  logic         wr_clk = 1'b0;
  logic         rd_clk = 1'b0;
  bit           w_run  = 1'b1;
  bit           r_run  = 1'b1;
  logic         wr_rst = 1'b0;
  logic         wr_en  = 1'b0;
  logic [W-1:0] wr_data = '0;
  logic         rd_rst = 1'b0;
  logic         rd_en  = 1'b0;
  logic [W-1:0] rd_data;

  logic [W-1:0] exp_q[$];
  int           n_vec = 0;
  int           n_bad = 0;
  int           wr_count = 0;
  bit           mon_on = 1'b0;
  bit           done = 1'b0;
  string        ph_tag = "R1";
  logic [W-1:0] last_seen = '0;

  // 8-unit write period (125 MHz at 1 ns units); unrelated 14-unit read period
  always #4 if (w_run) wr_clk = ~wr_clk;
  always #7 if (r_run) rd_clk = ~rd_clk;

  fieldmem_delay #(.WORD_W(W), .DEPTH(DEPTH)) dut_i (
    .wr_clk (wr_clk), .wr_rst (wr_rst), .wr_en (wr_en), .wr_data (wr_data),
    .rd_clk (rd_clk), .rd_rst (rd_rst), .rd_en (rd_en), .rd_data (rd_data)
  );

  task automatic check(input bit ok, input string tag,
                       input logic [W-1:0] act, input logic [W-1:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: rd_data=%h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // Driver: every enabled write pushes its word as an expected item.
  task automatic wr_cycle(input bit rst, input bit en, input logic [W-1:0] d);
    @(negedge wr_clk);
    wr_rst  = rst;
    wr_en   = en;
    wr_data = d;
    if (rst) begin
      exp_q.delete();
      wr_count = 0;
    end
    if (en) begin
      exp_q.push_back(d);
      wr_count++;
    end
  endtask

  task automatic wr_stream(input int n, input int seed, input bit gaps);
    for (int i = 0; i < n; i++) begin
      wr_cycle(1'b0, !(gaps && (i % 3 == 1)), W'((i * 5 + seed) & 15));
    end
    wr_cycle(1'b0, 1'b0, '0);
  endtask

  task automatic rd_cycle(input bit rst, input bit en);
    @(negedge rd_clk);
    rd_rst = rst;
    rd_en  = en;
    if (rst) mon_on = 1'b1;
  endtask

  // Issues exactly n enabled reads, with optional idle gaps.
  task automatic rd_stream(input int n, input bit gaps);
    int k = 0;
    int got = 0;
    while (got < n) begin
      bit en = !(gaps && (k % 4 == 2));
      rd_cycle(1'b0, en);
      if (en) got++;
      k++;
    end
    rd_cycle(1'b0, 1'b0);
  endtask

  // Monitor: pops one expected item per enabled read edge; checks hold otherwise.
  initial begin
    forever begin
      bit en_s;
      bit rst_s;
      @(posedge rd_clk);
      en_s  = rd_en;
      rst_s = rd_rst;
      @(negedge rd_clk);
      if (mon_on) begin
        if (en_s) begin
          if (exp_q.size() == 0) begin
            check(1'b0, {ph_tag, " underflow"}, rd_data, 'x);
          end else begin
            logic [W-1:0] e;
            e = exp_q.pop_front();
            check(rd_data === e, rst_s ? "R4 first word" : ph_tag, rd_data, e);
          end
          last_seen = rd_data;
        end else begin
          check(rd_data === last_seen, "R6 hold", rd_data, last_seen);
        end
      end
    end
  end

  initial begin
    #200000;
    if (!done) begin
      n_bad++;
      n_vec++;
      $display("FAIL watchdog: run did not complete");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge wr_clk);

    // Phase A (R1, R4): reset with write, block of words, then read back
    ph_tag = "R1";
    wr_cycle(1'b1, 1'b1, 4'h9);
    wr_stream(39, 3, 1'b0);
    rd_cycle(1'b1, 1'b1);
    rd_stream(39, 1'b0);
    repeat (3) rd_cycle(1'b0, 1'b0);

    // Phase B (R2, R6): resets without enable, gapped writes and reads
    ph_tag = "R2";
    wr_cycle(1'b1, 1'b0, 4'hF);
    wr_stream(30, 11, 1'b1);
    rd_cycle(1'b1, 1'b0);
    rd_cycle(1'b0, 1'b0);
    rd_stream(wr_count, 1'b1);

    // Phase C (R3, R5, R7): concurrent streams past the wrap
    ph_tag = "R7 R3 R5";
    fork
      begin
        wr_cycle(1'b1, 1'b1, 4'h2);
        wr_stream(99, 7, 1'b0);
      end
      begin
        wait (wr_count >= 12);
        rd_cycle(1'b1, 1'b1);
        rd_stream(99, 1'b0);
      end
    join

    // Phase D (R8): stop write clock high, later stop read clock low
    ph_tag = "R8";
    wr_cycle(1'b1, 1'b1, 4'h5);
    wr_stream(15, 1, 1'b0);
    @(posedge wr_clk);
    w_run = 1'b0;
    #600;
    w_run = 1'b1;
    wr_stream(15, 4, 1'b0);
    rd_cycle(1'b1, 1'b1);
    rd_stream(10, 1'b0);
    @(negedge rd_clk);
    r_run = 1'b0;
    #900;
    r_run = 1'b1;
    rd_stream(20, 1'b0);
    repeat (3) rd_cycle(1'b0, 1'b0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule